// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the per-controller core of an eight-input interrupt controller. It turns a set of raw request lines into one request towards the processor and the number of the line that wins. Each line is captured into a request register. A trigger-select register chooses, line by line, between two capture modes. In level mode the request bit follows the pin. In edge mode only a fresh rising input sets the bit, and the bit then stays set until the acknowledge side clears it.

The resolver works on requests that are not masked. It finds the best of them in a priority order that starts at a programmable rotation base, and compares it with the best in-service level supplied from outside. It raises its output only when the pending request strictly outranks everything already in service. On the master instance, a special nested flag removes the cascade line from the in-service comparison. A slave can then interrupt its own in-service request through the master. Acknowledge, end-of-interrupt handling and the programming sequence live outside this block. They drive the clear, in-service and write-enable inputs.

Top module: `irq_resolver`

## Requirements
- R1: For a line whose trigger-select bit is 1 (level mode), the request bit takes the value of the input line at every clock edge.
- R2: For a line whose trigger-select bit is 0 (edge mode), the request bit is set when the input is high and was low at the previous edge. A low input does not clear the bit.
- R3: A 1 on bit n of `req_clr` clears request bit n of an edge-mode line at the next edge, unless the same edge sets it again through R2.
- R4: A trigger-select write stores the written value ANDed with the parameter TRIG_WMASK (0xF8 by default; 0xDE for a slave). Bits outside that mask always read 0, which means edge mode.
- R5: A masked request (mask bit 1) never causes `int_req`. With every pending request masked, `int_req` is 0.
- R6: Priority rank k corresponds to line (k + rotation base) mod 8, and rank 0 is the highest. The rotation base is written through `rot_we`/`rot_wdata`.
- R7: `int_req` is 1 only when the best unmasked request has a strictly better rank than the best bit of `isr_in`. An equal rank does not raise the request.
- R8: On the master instance (IS_MASTER=1), when `nest_special` is 1, `isr_in` bit CASCADE_LINE (2) is left out of the in-service rank. The flag has no effect on a slave.
- R9: `int_line` gives the winning line number when `int_req` is 1, and 0 otherwise.
- R10: `int_req` and `int_line` are registered. They reflect the request, mask and rotation registers and the `isr_in`/`nest_special` inputs as they were just before the clock edge that updates the outputs.
- R11: Synchronous reset clears the request, last-level, mask, trigger-select and rotation registers and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Raw interrupt request lines |
| req_clr | input | 8 | Per-line clear of edge-captured requests, driven by the acknowledge logic |
| trig_we | input | 1 | Trigger-select write enable |
| trig_wdata | input | 8 | Trigger-select write data (1 = level mode) |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 8 | Mask write data (1 = masked) |
| rot_we | input | 1 | Rotation base write enable |
| rot_wdata | input | 3 | New rotation base (line with the highest priority) |
| isr_in | input | 8 | In-service bits from the acknowledge logic |
| nest_special | input | 1 | Special nested mode flag |
| trig_q | output | 8 | Trigger-select register readback |
| req_q | output | 8 | Request register readback |
| int_req | output | 1 | Registered interrupt request to the processor |
| int_line | output | 3 | Registered winning line number |

## Verification
Random traffic mixes every trigger-select, mask, rotation base and in-service pattern, with lines toggling at random. This exposes whether edge capture and level capture stay distinct per line, and whether the rank search wraps correctly for every base. The directed cases isolate single effects. One writes all ones to the trigger-select register and expects only the writable bits to come back. One captures two edge lines and then moves the rotation base, so the winner flips from the lower-numbered line to the higher-numbered one. One sets an in-service level of equal rank to show that a tie does not fire. One puts a request on line 5 against in-service bit 2, with and without special nesting, to show that the cascade bit is left out only when the flag is set.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int NLINES = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASCADE_LINE = 2,
  parameter logic [NLINES-1:0] TRIG_WMASK = 'hF8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_in,
  input  logic [NLINES-1:0] req_clr,
  input  logic              trig_we,
  input  logic [NLINES-1:0] trig_wdata,
  input  logic              mask_we,
  input  logic [NLINES-1:0] mask_wdata,
  input  logic              rot_we,
  input  logic [LW-1:0]     rot_wdata,
  input  logic [NLINES-1:0] isr_in,
  input  logic              nest_special,
  output logic [NLINES-1:0] trig_q,
  output logic [NLINES-1:0] req_q,
  output logic              int_req,
  output logic [LW-1:0]     int_line
);

  localparam logic [LW:0] NONE = (LW+1)'(NLINES);

  logic [NLINES-1:0] last_q, mask_q, req_nxt, pend, drop, isr_eff;
  logic [LW-1:0]     rot_q, win;
  logic [LW:0]       rank_pend, rank_isr;
  logic              fire;

  function automatic logic [LW:0] best_rank(input logic [NLINES-1:0] v,
                                            input logic [LW-1:0] base);
    logic [LW-1:0] idx;
    best_rank = NONE;
    for (int i = NLINES - 1; i >= 0; i--) begin
      idx = LW'(i) + base;
      if (v[idx]) best_rank = (LW+1)'(i);
    end
  endfunction

  generate
    if (IS_MASTER) begin : g_master
      assign drop = nest_special ? (NLINES'(1) << CASCADE_LINE) : '0;
    end else begin : g_slave
      assign drop = '0;
    end
  endgenerate

  assign req_nxt   = (trig_q & req_in)
                   | (~trig_q & ((req_q & ~req_clr) | (req_in & ~last_q)));
  assign pend      = req_q & ~mask_q;
  assign isr_eff   = isr_in & ~drop;
  assign rank_pend = best_rank(pend, rot_q);
  assign rank_isr  = best_rank(isr_eff, rot_q);
  assign fire      = rank_pend < rank_isr;
  assign win       = rank_pend[LW-1:0] + rot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      last_q   <= '0;
      mask_q   <= '0;
      trig_q   <= '0;
      rot_q    <= '0;
      int_req  <= 1'b0;
      int_line <= '0;
    end else begin
      req_q    <= req_nxt;
      last_q   <= req_in;
      if (trig_we) trig_q <= trig_wdata & TRIG_WMASK;
      if (mask_we) mask_q <= mask_wdata;
      if (rot_we)  rot_q  <= rot_wdata;
      int_req  <= fire;
      int_line <= fire ? win : '0;
    end
  end

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
      // R1
      level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        trig_q[g] |=> req_q[g] == $past(req_in[g]));
      // R2
      edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig_q[g] && req_q[g] && !req_clr[g]) |=> req_q[g]);
    end
  endgenerate

  // R5
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !int_req);

  // R9
  line_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> ((($past(pend) >> int_line) & NLINES'(1)) != '0));

  // R9
  line_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !int_req |-> int_line == '0);

endmodule

// File: tb/irq_resolver_bench.sv
module irq_resolver_bench;
  localparam int CLK = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] req_in = 0, req_clr = 0, trig_wdata = 0, mask_wdata = 0, isr_in = 0;
  logic trig_we = 0, mask_we = 0, rot_we = 0, nest_special = 0;
  logic [2:0] rot_wdata = 0;
  logic [7:0] trig_q, req_q;
  logic int_req;
  logic [2:0] int_line;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_req, m_last, m_trig, m_mask;
  logic [2:0] m_rot;
  logic e_req;
  logic [2:0] e_line;

  irq_resolver u_irq_resolver (
    .clk(clk), .rst(rst), .req_in(req_in), .req_clr(req_clr),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rot_we(rot_we), .rot_wdata(rot_wdata),
    .isr_in(isr_in), .nest_special(nest_special),
    .trig_q(trig_q), .req_q(req_q), .int_req(int_req), .int_line(int_line));

  always #(CLK/2) clk = ~clk;

  function automatic int rank(input logic [7:0] v, input logic [2:0] b);
    for (int i = 0; i < 8; i++) if (v[(i + b) % 8]) return i;
    return 8;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    int pp, pc;
    pp = rank(m_req & ~m_mask, m_rot);
    pc = rank(isr_in & ~(nest_special ? 8'h04 : 8'h00), m_rot);
    e_req  = pp < pc;
    e_line = e_req ? 3'((pp + m_rot) % 8) : 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (m_trig[i]) m_req[i] = req_in[i];
      else begin
        if (req_clr[i]) m_req[i] = 1'b0;
        if (req_in[i] && !m_last[i]) m_req[i] = 1'b1;
      end
    end
    m_last = req_in;
    if (trig_we) m_trig = trig_wdata & 8'hF8;
    if (mask_we) m_mask = mask_wdata;
    if (rot_we)  m_rot  = rot_wdata;
    @(posedge clk); #1;
    check("R1 R2 R3 req_q", req_q, m_req);
    check("R4 trig_q", trig_q, m_trig);
    check("R5 R6 R7 R8 R10 int_req", int_req, e_req);
    check("R9 int_line", int_line, e_line);
  endtask

  task automatic idle_inputs();
    trig_we = 0; mask_we = 0; rot_we = 0; req_clr = 0;
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    // R11
    check("R11 reset req_q", req_q, 0);
    check("R11 reset int_req", int_req, 0);
    check("R11 reset trig_q", trig_q, 0);
    rst = 0;
    m_req = 0; m_last = 0; m_trig = 0; m_mask = 0; m_rot = 0;

    // R4: only writable bits stick
    trig_we = 1; trig_wdata = 8'hFF; cycle(); idle_inputs();
    check("R4 masked write", trig_q, 8'hF8);
    trig_we = 1; trig_wdata = 8'h00; cycle(); idle_inputs();

    // R2 and R6: edge lines 1 and 6, base 0 then base 5
    req_in = 8'h42; cycle(); req_in = 8'h00; cycle(); cycle();
    check("R2 edge held after fall", req_q, 8'h42);
    check("R6 base0 winner", int_line, 1);
    rot_we = 1; rot_wdata = 3'd5; cycle(); idle_inputs(); cycle();
    check("R6 base5 winner", int_line, 6);

    // R7: in-service line 6 has equal rank, no request
    isr_in = 8'h40; cycle(); cycle();
    check("R7 equal rank blocked", int_req, 0);
    isr_in = 8'h00;
    // R3: clear both edge requests
    req_clr = 8'h42; cycle(); idle_inputs(); cycle();
    check("R3 cleared", req_q, 8'h00);
    check("R5 nothing pending", int_req, 0);

    // R8: line 5 pending against in-service cascade bit 2
    rot_we = 1; rot_wdata = 3'd0; cycle(); idle_inputs();
    req_in = 8'h20; isr_in = 8'h04; cycle(); cycle();
    check("R8 blocked without flag", int_req, 0);
    nest_special = 1; cycle();
    check("R8 fires with flag", int_req, 1);
    check("R9 line 5", int_line, 5);
    // R5: mask line 5
    mask_we = 1; mask_wdata = 8'h20; cycle(); idle_inputs(); cycle();
    check("R5 masked", int_req, 0);
    nest_special = 0; isr_in = 0; req_in = 0;

    // R1: level line 4 follows the pin
    trig_we = 1; trig_wdata = 8'h10; mask_we = 1; mask_wdata = 0; cycle(); idle_inputs();
    req_in = 8'h10; cycle(); req_in = 8'h00; cycle();
    check("R1 level drops", req_q[4], 0);

    for (int n = 0; n < 3000; n++) begin
      req_in  = 8'($urandom);
      req_clr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      trig_we = ($urandom % 16) == 0; trig_wdata = 8'($urandom);
      mask_we = ($urandom % 8) == 0;  mask_wdata = 8'($urandom) & 8'($urandom);
      rot_we  = ($urandom % 8) == 0;  rot_wdata  = 3'($urandom);
      isr_in  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      nest_special = 1'($urandom);
      cycle();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule